// File: doc/BRIEF.md
# Branch Target Buffer with Timestamp Replacement

This block is a fully associative table of branch records for an instruction fetch path. Each of its 64 slots holds the address of a branch, the address it jumps to, a 2-bit saturating confidence counter and a 10-bit record of when the slot was last used. A single operation arrives each cycle with an instruction PC and a target address. The block can search the table, train a counter, add a branch, or wipe the whole table.

Replacement relies on one global time counter. Each slot that a lookup hit or an insert touches takes the current time as its stamp, and the time then advances by one. A new branch goes into the slot with the lowest stamp. A slot whose counter predicts fall-through stays in the table like any other slot. When the time counter is about to roll over, the block halves every stamp and the counter in the same cycle, which keeps the age order.

The hit, prediction and target outputs are combinational in the cycle that carries the operation. All table and time updates take effect on the rising clock edge that ends that cycle.

Top module: `btb_top`

## Requirements
- R1: Synchronous active-high reset and the clear operation (code 000) set every slot's tag, target, counter and stamp to zero and set the global time to 1. As a result, a lookup of PC 0 right after a clear hits with prediction 0 and target 0.
- R2: A lookup (code 001) whose PC matches no tag drives hit 0, prediction 0 and target 0, and leaves the table and the time unchanged.
- R3: A lookup that matches drives hit 1, sets the prediction to bit 1 of the slot's counter (1 means taken, 0 means fall-through) and outputs the slot's stored target. When several slots carry the same tag, the lowest-indexed one is used.
- R4: On a lookup hit, the matching slot's stamp becomes the current global time, and the time then increments.
- R5: Verify fall-through (code 010) drives hit 1 if the PC matches. It then decrements that slot's counter, stopping at 0. It changes neither the stamps nor the time, and it drives prediction 0 and target 0.
- R6: Verify target (code 011) drives hit 1 if the PC matches. It then increments that slot's counter, stopping at 3, and writes the input target into the slot. It does not touch the stamps or the time.
- R7: Insert fall-through (code 110) picks the victim slot with the smallest stamp. It writes the PC as the tag, sets the counter to 1, sets the stamp to the global time and increments the time. The slot's old target is kept.
- R8: Insert target (code 111) does everything insert fall-through does, except that it sets the counter to 2 and also writes the input target into the slot.
- R9: When several slots share the smallest stamp, the lowest index is the victim. After a clear, successive inserts therefore fill slots 0, 1, 2 and so on, in order.
- R10: When an operation advances the time while the time is 1023, every stamp is shifted right by one bit, the touched slot gets stamp 512, and the time becomes 513. The time is never 0.
- R11: Clear and both inserts drive hit 0. Codes 100 and 101 are no-operations: they drive all outputs to 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, same effect as clear |
| op_i | input | 3 | Operation code |
| pc_i | input | 32 | Instruction PC used as the search key or the new tag |
| target_i | input | 32 | Target address for verify target and insert target |
| hit_o | output | 1 | The PC matched a tag during a lookup or verify |
| pred_o | output | 1 | Predicted direction on a lookup hit, 1 = taken |
| target_o | output | 32 | Stored target on a lookup hit, otherwise 0 |

## Verification
The assertions check on every cycle the rules that concern the global time and the output qualification. These are: the time returns to 1 after a clear, advances by exactly one on an insert, jumps to 513 at rollover, stays put during verifies and never reads 0, and the hit, prediction and target outputs stay quiet outside their operations. The slot contents are another matter. Victim choice, the tie order after a clear, counter saturation, the rule that an insert fall-through keeps the old target, and the stamp halving at rollover are all visible only through later lookups. The bench scenarios therefore exercise these through directed fills and evictions and through a long random run, which a reference model checks across several rollovers.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [2:0] {
        OP_CLEAR   = 3'b000,
        OP_LOOKUP  = 3'b001,
        OP_VER_FT  = 3'b010,
        OP_VER_TK  = 3'b011,
        OP_NOP_A   = 3'b100,
        OP_NOP_B   = 3'b101,
        OP_INS_FT  = 3'b110,
        OP_INS_TK  = 3'b111
    } btb_op_e;

    localparam int CNT_W       = 2;
    localparam logic [CNT_W-1:0] CNT_INS_FT = 2'd1;
    localparam logic [CNT_W-1:0] CNT_INS_TK = 2'd2;

    // Decoded view of one operation code.
    typedef struct packed {
        logic clear;
        logic lookup;
        logic verify;
        logic insert;
        logic taken;
    } btb_dec_t;

    function automatic btb_dec_t decode_op(input logic [2:0] code);
        btb_dec_t d;
        d.clear  = (code == OP_CLEAR);
        d.lookup = (code == OP_LOOKUP);
        d.verify = (code[2:1] == 2'b01);
        d.insert = (code[2:1] == 2'b11);
        d.taken  = code[0];
        return d;
    endfunction

    function automatic logic [CNT_W-1:0] cnt_up(input logic [CNT_W-1:0] c);
        return (c == {CNT_W{1'b1}}) ? c : c + 1'b1;
    endfunction

    function automatic logic [CNT_W-1:0] cnt_down(input logic [CNT_W-1:0] c);
        return (c == '0) ? c : c - 1'b1;
    endfunction

endpackage

// File: rtl/btb_match.sv
module btb_match #(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ADDR_W-1:0] tags  [ENTRIES],
    input  logic [ADDR_W-1:0] key,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    logic [ENTRIES-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign eq[g] = (tags[g] == key);
        end
    endgenerate

    // Lowest index wins among duplicate tags.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
    parameter int ENTRIES = 64,
    parameter int STAMP_W = 10,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [STAMP_W-1:0] stamps [ENTRIES],
    output logic [IDX_W-1:0]   idx
);
    logic [STAMP_W-1:0] best;

    // Strict less-than keeps the lowest index on ties.
    always_comb begin
        best = stamps[0];
        idx  = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            if (stamps[i] < best) begin
                best = stamps[i];
                idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/btb_clock.sv
module btb_clock #(
    parameter int STAMP_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               advance,
    output logic [STAMP_W-1:0] time_q,
    output logic               wrap,
    output logic [STAMP_W-1:0] stamp_now
);
    localparam logic [STAMP_W-1:0] T_MAX  = {STAMP_W{1'b1}};
    localparam logic [STAMP_W-1:0] T_HALF = {1'b1, {(STAMP_W-1){1'b0}}};
    localparam logic [STAMP_W-1:0] T_ONE  = {{(STAMP_W-1){1'b0}}, 1'b1};

    assign wrap      = advance && (time_q == T_MAX);
    assign stamp_now = wrap ? T_HALF : time_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            time_q <= T_ONE;
        end else if (advance) begin
            time_q <= stamp_now + T_ONE;
        end
    end
endmodule

// File: rtl/btb_top.sv
module btb_top #(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int STAMP_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic              hit_o,
    output logic              pred_o,
    output logic [ADDR_W-1:0] target_o
);
    import btb_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ADDR_W-1:0]  tag_q   [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q   [ENTRIES];
    logic [CNT_W-1:0]   cnt_q   [ENTRIES];
    logic [STAMP_W-1:0] stamp_q [ENTRIES];

    btb_dec_t           dec;
    logic               m_found;
    logic [IDX_W-1:0]   m_idx;
    logic [IDX_W-1:0]   v_idx;
    logic [IDX_W-1:0]   touch_idx;
    logic               advance;
    logic               wrap;
    logic [STAMP_W-1:0] time_q;
    logic [STAMP_W-1:0] stamp_now;
    logic               look_hit;

    assign dec = decode_op(op_i);

    btb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
        .tags  (tag_q),
        .key   (pc_i),
        .found (m_found),
        .idx   (m_idx)
    );

    btb_victim #(.ENTRIES(ENTRIES), .STAMP_W(STAMP_W), .IDX_W(IDX_W)) u_victim (
        .stamps (stamp_q),
        .idx    (v_idx)
    );

    assign look_hit  = dec.lookup && m_found;
    assign advance   = look_hit || dec.insert;
    assign touch_idx = dec.insert ? v_idx : m_idx;

    btb_clock #(.STAMP_W(STAMP_W)) u_clock (
        .clk       (clk),
        .rst       (rst),
        .clr       (dec.clear),
        .advance   (advance),
        .time_q    (time_q),
        .wrap      (wrap),
        .stamp_now (stamp_now)
    );

    assign hit_o    = (dec.lookup || dec.verify) && m_found;
    assign pred_o   = look_hit && cnt_q[m_idx][CNT_W-1];
    assign target_o = look_hit ? tgt_q[m_idx] : '0;

    always_ff @(posedge clk) begin
        if (rst || dec.clear) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]   <= '0;
                tgt_q[i]   <= '0;
                cnt_q[i]   <= '0;
                stamp_q[i] <= '0;
            end
        end else begin
            if (wrap) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    stamp_q[i] <= stamp_q[i] >> 1;
                end
            end
            if (advance) begin
                stamp_q[touch_idx] <= stamp_now;
            end
            if (dec.verify && m_found) begin
                if (dec.taken) begin
                    cnt_q[m_idx] <= cnt_up(cnt_q[m_idx]);
                    tgt_q[m_idx] <= target_i;
                end else begin
                    cnt_q[m_idx] <= cnt_down(cnt_q[m_idx]);
                end
            end
            if (dec.insert) begin
                tag_q[v_idx] <= pc_i;
                if (dec.taken) begin
                    cnt_q[v_idx] <= CNT_INS_TK;
                    tgt_q[v_idx] <= target_i;
                end else begin
                    cnt_q[v_idx] <= CNT_INS_FT;
                end
            end
        end
    end
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int ADDR_W  = 32,
    parameter int STAMP_W = 10
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         op_i,
    input logic               hit_o,
    input logic               pred_o,
    input logic [ADDR_W-1:0]  target_o,
    input logic [STAMP_W-1:0] time_q
);
    localparam logic [STAMP_W-1:0] T_MAX  = {STAMP_W{1'b1}};
    localparam logic [STAMP_W-1:0] T_RENEW = {1'b1, {(STAMP_W-2){1'b0}}, 1'b1};

    logic is_insert;
    logic is_verify;
    assign is_insert = (op_i[2:1] == 2'b11);
    assign is_verify = (op_i[2:1] == 2'b01);

    AST_HIT_ONLY_SEARCH: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (op_i == 3'b001 || is_verify));                              // R11
    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        !(op_i == 3'b001 && hit_o) |-> (!pred_o && target_o == '0));           // R2
    AST_CLEAR_TIME: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b000) |=> (time_q == STAMP_W'(1)));                         // R1
    AST_TIME_NONZERO: assert property (@(posedge clk) disable iff (rst)
        time_q != '0);                                                          // R10
    AST_INSERT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (is_insert && time_q != T_MAX) |=> (time_q == STAMP_W'($past(time_q) + 1'b1))); // R7
    AST_WRAP_RENEW: assert property (@(posedge clk) disable iff (rst)
        (is_insert && time_q == T_MAX) |=> (time_q == T_RENEW));                // R10
    AST_VERIFY_HOLDS_TIME: assert property (@(posedge clk) disable iff (rst)
        is_verify |=> $stable(time_q));                                         // R5
endmodule

bind btb_top btb_checker #(.ADDR_W(ADDR_W), .STAMP_W(STAMP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .hit_o    (hit_o),
    .pred_o   (pred_o),
    .target_o (target_o),
    .time_q   (time_q)
);

// File: tb/sim_btb_top.sv
module sim_btb_top;
    localparam int N    = 64;
    localparam int TMAX = 1023;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = 3'b100;
    logic [31:0] pc_i = '0;
    logic [31:0] target_i = '0;
    logic        hit_o;
    logic        pred_o;
    logic [31:0] target_o;

    int checks = 0;
    int failures = 0;
    int wraps = 0;

    logic [31:0] m_tag [N];
    logic [31:0] m_tgt [N];
    logic [1:0]  m_cnt [N];
    int          m_stamp [N];
    int          m_time;

    always #5 clk = ~clk;

    btb_top u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .pc_i(pc_i), .target_i(target_i),
        .hit_o(hit_o), .pred_o(pred_o), .target_o(target_o)
    );

    function automatic int m_find(input logic [31:0] pc);
        for (int i = 0; i < N; i++) if (m_tag[i] == pc) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        int v = 0;
        for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[v]) v = i;
        return v;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < N; i++) begin
            m_tag[i] = '0; m_tgt[i] = '0; m_cnt[i] = '0; m_stamp[i] = 0;
        end
        m_time = 1;
    endtask

    task automatic m_touch(input int idx);
        if (m_time == TMAX) begin
            for (int i = 0; i < N; i++) m_stamp[i] = m_stamp[i] / 2;
            m_stamp[idx] = 512;
            m_time = 513;
            wraps++;
        end else begin
            m_stamp[idx] = m_time;
            m_time++;
        end
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000: return "R1";
            3'b001: return "R3";
            3'b010: return "R5";
            3'b011: return "R6";
            3'b110: return "R7";
            3'b111: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic h, input logic p,
                         input logic [31:0] t, input logic eh, input logic ep,
                         input logic [31:0] et);
        checks++;
        if (h !== eh || p !== ep || t !== et) begin
            failures++;
            $display("FAIL %s: hit/pred/target actual %b/%b/%h expected %b/%b/%h",
                     req, h, p, t, eh, ep, et);
        end
    endtask

    // Drive one operation, compare outputs with the model, update the model.
    task automatic do_op(input logic [2:0] op, input logic [31:0] pc,
                         input logic [31:0] tg, input string req);
        int f;
        logic eh, ep;
        logic [31:0] et;
        @(negedge clk);
        op_i = op; pc_i = pc; target_i = tg;
        #2;
        f = m_find(pc);
        eh = 1'b0; ep = 1'b0; et = '0;
        if ((op == 3'b001 || op[2:1] == 2'b01) && f >= 0) eh = 1'b1;
        if (op == 3'b001 && f >= 0) begin ep = m_cnt[f][1]; et = m_tgt[f]; end
        check((req == "") ? req_of(op) : req, hit_o, pred_o, target_o, eh, ep, et);
        case (op)
            3'b000: m_clear();
            3'b001: if (f >= 0) m_touch(f);
            3'b010: if (f >= 0) m_cnt[f] = (m_cnt[f] == 0) ? 2'd0 : m_cnt[f] - 1'b1;
            3'b011: if (f >= 0) begin
                        m_cnt[f] = (m_cnt[f] == 3) ? 2'd3 : m_cnt[f] + 1'b1;
                        m_tgt[f] = tg;
                    end
            3'b110, 3'b111: begin
                int v = m_victim();
                m_tag[v] = pc;
                m_cnt[v] = op[0] ? 2'd2 : 2'd1;
                if (op[0]) m_tgt[v] = tg;
                m_touch(v);
            end
            default: ;
        endcase
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state; zero tags make PC 0 hit
        do_op(3'b001, 32'h0, 32'h0, "R1");
        // R2: miss
        do_op(3'b001, 32'h0000_1234, 32'h0, "R2");

        // R7, R8, R3
        do_op(3'b111, 32'hA000_0000, 32'hBEEF_0000, "R8");
        do_op(3'b110, 32'hA000_0004, 32'hDEAD_DEAD, "R7");
        do_op(3'b001, 32'hA000_0000, 32'h0, "R3");
        do_op(3'b001, 32'hA000_0004, 32'h0, "R7");
        // R6: training to saturation, target overwrite
        do_op(3'b011, 32'hA000_0004, 32'h1111_2222, "R6");
        do_op(3'b011, 32'hA000_0004, 32'h3333_4444, "R6");
        do_op(3'b011, 32'hA000_0004, 32'h5555_6666, "R6");
        do_op(3'b001, 32'hA000_0004, 32'h0, "R6");
        // R5: down to zero and saturate
        for (int k = 0; k < 4; k++) do_op(3'b010, 32'hA000_0004, 32'h0, "R5");
        do_op(3'b001, 32'hA000_0004, 32'h0, "R5");
        do_op(3'b010, 32'hFFFF_0000, 32'h0, "R5");
        // R11: no-op codes and quiet hit for insert/clear
        do_op(3'b100, 32'hA000_0000, 32'h0, "R11");
        do_op(3'b101, 32'hA000_0000, 32'h7, "R11");
        do_op(3'b001, 32'hA000_0000, 32'h0, "R11");

        // R9: fill in index order after clear, slot 0 evicted first
        do_op(3'b000, 32'h0, 32'h0, "R1");
        for (int k = 0; k < N; k++) do_op(3'b111, 32'h2000_0000 + k * 4, 32'h7000_0000 + k, "R9");
        do_op(3'b110, 32'h3000_0000, 32'h0, "R9");
        do_op(3'b001, 32'h2000_0000, 32'h0, "R9");
        do_op(3'b001, 32'h2000_0004, 32'h0, "R9");
        // R4: a lookup refreshes the stamp, so the next oldest is evicted
        do_op(3'b001, 32'h2000_0008, 32'h0, "R4");
        do_op(3'b111, 32'h3000_0004, 32'h1, "R4");
        do_op(3'b001, 32'h2000_0008, 32'h0, "R4");
        do_op(3'b001, 32'h2000_000C, 32'h0, "R4");
        // R3: duplicate tags, lowest index serves the lookup
        do_op(3'b111, 32'h3000_0004, 32'h2, "R3");
        do_op(3'b001, 32'h3000_0004, 32'h0, "R3");

        // R10 and everything else: random mix across several rollovers
        void'($urandom(32'd1234));
        for (int k = 0; k < 5000; k++) begin
            int r = $urandom_range(0, 99);
            logic [2:0] op;
            logic [31:0] pc = 32'h0004_0000 + $urandom_range(0, 79) * 4;
            if (r < 40) op = 3'b001;
            else if (r < 52) op = 3'b010;
            else if (r < 64) op = 3'b011;
            else if (r < 80) op = 3'b110;
            else if (r < 98) op = 3'b111;
            else op = 3'b100 | 3'($urandom_range(0, 1));
            do_op(op, pc, $urandom(), "");
        end
        // R10: the run must have crossed the rollover point
        checks++;
        if (wraps < 2) begin
            failures++;
            $display("FAIL R10: rollovers actual %0d expected >= 2", wraps);
        end
        // R1: clear after the random run
        do_op(3'b000, 32'h0, 32'h0, "R1");
        do_op(3'b001, 32'h0, 32'h0, "R1");

        finish_run();
    end
endmodule